// File: doc/BRIEF.md
# Consecutive Out-of-Limit Alert Filter

This block sits behind a measurement comparator and keeps a single noisy reading from raising an alarm. After each finished conversion the comparator gives it a strobe and a flag saying whether the result was outside limits. The block counts how many flagged results arrive in a row. It raises `alert` only when that run reaches a threshold of one to four, which software programs.

The threshold lives in one 8-bit configuration byte that software reaches through a simple register port. The same byte holds an unrelated enable bit for the serial-bus timeout logic, and the block passes that bit straight out on a pin. The block does no limit comparison and has no timeout counter.

Top module: `alert_streak_filter`

## Requirements
- R1: After reset, `alert` is 0, `timeout_en` is 0 and the configuration byte reads 00h.
- R2: The configuration byte sits at address 22h. A write there with `reg_we` high stores all eight bits. `reg_rdata` returns the stored byte combinationally while `reg_addr` is 22h and returns 00h at any other address. A write to any other address changes nothing.
- R3: `timeout_en` equals bit 7 of the stored byte and follows a write in the next cycle.
- R4: Bits 3:1 encode the run length needed. 000 needs 1 result, 001 needs 2, 011 needs 3 and 111 needs 4.
- R5: Unlisted patterns in bits 3:1 decode by their highest set bit. 1xx needs 4, 01x needs 3 and 001 needs 2.
- R6: On a `conv_done` strobe with `out_of_limit` high, the run count grows by one. `alert` is high in the cycle after the strobe that brings the run to the needed length.
- R7: A `conv_done` strobe with `out_of_limit` low clears the run count. `alert` is low in the next cycle.
- R8: The run count saturates at 4. `alert` stays high for as long as further out-of-limit results keep arriving.
- R9: A write to address 22h clears the run count, and `alert` is low in the next cycle. A `conv_done` strobe in the same cycle as that write is ignored.
- R10: While `conv_done` is low, `out_of_limit` has no effect and `alert` holds its value.
- R11: Bits 6:4 and bit 0 do not change the threshold. They are still stored and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| conv_done | input | 1 | One-cycle strobe per finished conversion |
| out_of_limit | input | 1 | Result of that conversion was outside limits |
| alert | output | 1 | Filtered alarm |
| timeout_en | output | 1 | Serial-bus timeout enable, bit 7 of the configuration byte |

## Verification
Each result has a fixed due cycle:
- Read data is combinational, so it is due in the same cycle the address is presented.
- `alert` and `timeout_en` each pass through one register, so they are due one cycle after the strobe or write that moves them.

The driver drives every input just after a rising edge. At that point it stamps each expected value with its due cycle. The monitor samples at the following falling edges and compares only the entries whose stamp matches the current cycle. Any entry left over past its stamp counts as a failure.

// File: rtl/alert_streak_filter.sv
module alert_streak_filter #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h22,
  parameter int RUN_MAX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              conv_done,
  input  logic              out_of_limit,
  output logic              alert,
  output logic              timeout_en
);
  localparam int CNT_W = $clog2(RUN_MAX + 1);
  localparam logic [CNT_W-1:0] RUN_TOP = CNT_W'(RUN_MAX);

  logic [7:0]       cfg_q;
  logic [CNT_W-1:0] run_q, run_nx, need;
  logic             alert_q;

  wire cfg_hit = (reg_addr == CFG_ADDR);
  wire wr_hit  = reg_we && cfg_hit;

  always_comb begin
    if (cfg_q[3])      need = CNT_W'(4);
    else if (cfg_q[2]) need = CNT_W'(3);
    else if (cfg_q[1]) need = CNT_W'(2);
    else               need = CNT_W'(1);
  end

  assign run_nx = !out_of_limit ? '0 :
                  (run_q == RUN_TOP) ? run_q : run_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= 8'h00;
      run_q   <= '0;
      alert_q <= 1'b0;
    end else if (wr_hit) begin
      cfg_q   <= reg_wdata;
      run_q   <= '0;
      alert_q <= 1'b0;
    end else if (conv_done) begin
      run_q   <= run_nx;
      alert_q <= (run_nx >= need);
    end
  end

  assign reg_rdata  = cfg_hit ? cfg_q : 8'h00;
  assign alert      = alert_q;
  assign timeout_en = cfg_q[7];
endmodule

module alert_streak_filter_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              conv_done,
  input logic              out_of_limit,
  input logic              alert,
  input logic              timeout_en,
  input logic [7:0]        cfg_q
);
  logic hit;
  assign hit = reg_we && (reg_addr == CFG_ADDR);

  a_r3_timeout_follows: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (timeout_en == $past(reg_wdata[7])));

  a_r6_single_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && out_of_limit && !hit && cfg_q[3:1] == 3'b000) |=> alert);

  a_r7_in_limit_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !out_of_limit && !hit) |=> !alert);

  a_r8_persist: assert property (@(posedge clk) disable iff (!rst_n)
    (alert && conv_done && out_of_limit && !hit) |=> alert);

  a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !alert);

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_done && !hit) |=> $stable(alert));
endmodule

bind alert_streak_filter alert_streak_filter_chk #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .conv_done(conv_done), .out_of_limit(out_of_limit),
  .alert(alert), .timeout_en(timeout_en), .cfg_q(cfg_q)
);

// File: tb/tb_alert_streak_filter.sv
module tb_alert_streak_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       conv_done = 1'b0;
  logic       out_of_limit = 1'b0;
  logic       alert;
  logic       timeout_en;

  alert_streak_filter dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_done(conv_done),
    .out_of_limit(out_of_limit), .alert(alert), .timeout_en(timeout_en)
  );

  always #2 clk = ~clk;

  typedef struct {
    int         due;
    int         kind;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int cycle = 0;
  int checks = 0;
  int errors = 0;
  bit done_all = 1'b0;

  logic [7:0] m_cfg = 8'h00;
  int         m_run = 0;
  logic       m_alert = 1'b0;

  always @(posedge clk) cycle <= cycle + 1;

  function automatic int need_of(logic [7:0] c);
    if (c[3]) return 4;
    if (c[2]) return 3;
    if (c[1]) return 2;
    return 1;
  endfunction

  task automatic push(int due, int kind, logic [7:0] exp, string req);
    item_t it;
    it.due = due; it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic step(bit we, logic [7:0] addr, logic [7:0] wd, bit dn, bit oor, string req);
    @(posedge clk);
    #1;
    reg_we = we; reg_addr = addr; reg_wdata = wd;
    conv_done = dn; out_of_limit = oor;
    push(cycle, 2, (addr == 8'h22) ? m_cfg : 8'h00, req);
    if (we && addr == 8'h22) begin
      m_cfg = wd; m_run = 0; m_alert = 1'b0;
    end else if (dn) begin
      if (oor) m_run = (m_run == 4) ? 4 : m_run + 1;
      else     m_run = 0;
      m_alert = (m_run >= need_of(m_cfg));
    end
    push(cycle + 1, 0, {7'd0, m_alert}, req);
    push(cycle + 1, 1, {7'd0, m_cfg[7]}, req);
  endtask

  task automatic conv(bit oor, string req);
    step(1'b0, 8'h22, 8'h00, 1'b1, oor, req);
  endtask

  task automatic wr(logic [7:0] d, string req);
    step(1'b1, 8'h22, d, 1'b0, 1'b0, req);
  endtask

  task automatic idle(bit oor, string req);
    step(1'b0, 8'h22, 8'h00, 1'b0, oor, req);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cycle) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = {7'd0, alert};
        1: act = {7'd0, timeout_en};
        default: act = reg_rdata;
      endcase
      checks++;
      if (it.due != cycle || act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h", it.req, it.kind, cycle, act, it.exp);
      end
    end
  end

  initial begin
    #400000;
    if (!done_all) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    idle(1'b0, "R1");
    // R6 default threshold of one
    conv(1'b1, "R6");
    // R7 in-limit clears
    conv(1'b0, "R7");
    // R2 write/read, R3 timeout enable
    wr(8'h82, "R3");
    idle(1'b0, "R2");
    // R2 other address write ignored and reads zero
    step(1'b1, 8'h23, 8'hFF, 1'b0, 1'b0, "R2");
    step(1'b0, 8'h21, 8'h00, 1'b0, 1'b0, "R2");
    idle(1'b0, "R2");
    // R4 code 001 -> 2
    conv(1'b1, "R4");
    conv(1'b1, "R4");
    conv(1'b0, "R7");
    // R4 code 011 -> 3, R10 idle ignored
    wr(8'h06, "R4");
    conv(1'b1, "R4");
    idle(1'b1, "R10");
    conv(1'b1, "R4");
    idle(1'b1, "R10");
    conv(1'b1, "R4");
    // R9 write clears alert
    wr(8'h0E, "R9");
    // R4 code 111 -> 4, R8 saturation
    for (int i = 0; i < 4; i++) conv(1'b1, "R4");
    for (int i = 0; i < 6; i++) conv(1'b1, "R8");
    idle(1'b1, "R10");
    idle(1'b0, "R10");
    conv(1'b0, "R7");
    // R5 unlisted 100 -> 4
    wr(8'h08, "R5");
    for (int i = 0; i < 4; i++) conv(1'b1, "R5");
    // R5 unlisted 010 -> 3
    wr(8'h04, "R5");
    for (int i = 0; i < 3; i++) conv(1'b1, "R5");
    // R5 unlisted 101 -> 4
    wr(8'h0A, "R5");
    for (int i = 0; i < 4; i++) conv(1'b1, "R5");
    // R11 don't-care bits: 0x71 behaves as 1, read back intact
    wr(8'h71, "R11");
    idle(1'b0, "R11");
    conv(1'b1, "R11");
    // R9 write with simultaneous conversion: conversion ignored
    wr(8'h02, "R9");
    step(1'b1, 8'h22, 8'h02, 1'b1, 1'b1, "R9");
    conv(1'b1, "R9");
    conv(1'b1, "R9");
    // R3 timeout disable
    wr(8'h00, "R3");
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (q.size() != 0) begin
      errors++; checks++;
      $display("FAIL leftover: actual=%0d expected=0", q.size());
    end
    done_all = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule